// File: doc/BRIEF.md
# Peripheral Chip-Select with Wait-State Control

This block decodes bus cycles for a bank of peripherals. Software programs a 16-bit control word with a start address, a wait-state count and a ready-mode bit. When the bus begins a cycle, the block compares the upper address bits with the programmed start value. Any address at or above that value selects the bank. A selected cycle raises the chip-select and holds it until the block signals that the cycle may end.

The cycle ends after a minimum number of wait states, from zero to three. In one mode, the external ready line must also be high before the cycle can finish, and each clock with ready low adds a wait state. In the other mode, ready is ignored and the count alone ends the cycle. Cycles that do not select the bank produce neither a chip-select nor a done pulse; other decoders handle them.

After reset the block is disarmed. It selects nothing until software first touches the control register, either by reading it or by writing it.

Top module: `periph_select_ctl`

## Requirements
- R1: After reset, `cs_o` and `cyc_done` are low and `reg_rdata` reads 0x0003. That value means a start field of 0, the ready-ignore bit clear and a wait count of 3.
- R2: From reset until the first clock with `reg_rd` or `reg_wr` high, no bus cycle asserts `cs_o`.
- R3: Control word layout: bits 15:9 hold the start field, bit 2 is ready-ignore, and bits 1:0 are the wait count. Bits 8:3 always read 0, and writing them has no effect.
- R4: A memory cycle (`cyc_io`=0) is selected when `cyc_addr[19:13]` is greater than or equal to the start field.
- R5: An I/O cycle (`cyc_io`=1) treats `cyc_addr[19:16]` as zero in the comparison. A start field with any of its top four bits set therefore never selects an I/O cycle.
- R6: `cs_o` rises on the clock after the `cyc_start` pulse of a selected cycle. It falls on the clock after the one on which `cyc_done` is high.
- R7: With ready-ignore set, `cyc_done` is high in selected clock W+1, where W is the wait count, whatever `bus_rdy` does.
- R8: With ready-ignore clear, `cyc_done` is high in the first selected clock that has at least W clocks before it and has `bus_rdy` high.
- R9: An unselected cycle leaves `cs_o` and `cyc_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_rd | input | 1 | Control register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Current control word |
| cyc_start | input | 1 | One-clock pulse at the start of a bus cycle |
| cyc_addr | input | 20 | Bus cycle address |
| cyc_io | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| bus_rdy | input | 1 | External ready |
| cs_o | output | 1 | Chip-select, active high |
| cyc_done | output | 1 | Cycle may complete in this clock |

## Verification
The bench probes the comparison exactly at the start boundary and one step below it. A design using a strict greater-than comparison would drop the boundary address, and a design using equality would miss the address far above the start value. It drives an I/O cycle whose high address bits would select as a memory cycle, which catches a decoder that forgets to zero those bits. It holds ready low past the wait count in one mode and leaves it low in the other. A design that mixes up the two modes will end the cycle early or hang. It also issues a bus cycle right after reset, when the reset start value would match any address, to catch a block that arms itself without a register access.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int ADDR_W    = 20;
  localparam int DATA_W    = 16;
  localparam int START_W   = 7;
  localparam int WS_W      = 2;
  localparam int IO_ADDR_W = 16;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } cyc_st_t;
endpackage

// File: rtl/pcs_regs.sv
module pcs_regs #(
  parameter int DATA_W  = 16,
  parameter int START_W = 7,
  parameter int WS_W    = 2,
  parameter int WS_RST  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [START_W-1:0] start_o,
  output logic               nordy_o,
  output logic [WS_W-1:0]    ws_o,
  output logic               armed_o
);
  localparam int START_LO = DATA_W - START_W;
  localparam int NORDY_B  = WS_W;

  logic [START_W-1:0] start_q, start_d;
  logic               nordy_q, nordy_d;
  logic [WS_W-1:0]    ws_q, ws_d;
  logic               armed_q, armed_d;
  logic               cfg_en;

  // next state
  always_comb begin
    cfg_en  = wr;
    start_d = wdata[DATA_W-1:START_LO];
    nordy_d = wdata[NORDY_B];
    ws_d    = wdata[WS_W-1:0];
    armed_d = armed_q | wr | rd;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      nordy_q <= 1'b0;
      ws_q    <= WS_W'(WS_RST);
      armed_q <= 1'b0;
    end else begin
      if (cfg_en) begin
        start_q <= start_d;
        nordy_q <= nordy_d;
        ws_q    <= ws_d;
      end
      armed_q <= armed_d;
    end
  end

  // read-back: reserved bits tie to zero
  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i >= START_LO) begin : g_start
      assign rdata[i] = start_q[i-START_LO];
    end else if (i == NORDY_B) begin : g_nordy
      assign rdata[i] = nordy_q;
    end else if (i < WS_W) begin : g_ws
      assign rdata[i] = ws_q[i];
    end else begin : g_rsvd
      assign rdata[i] = 1'b0;
    end
  end

  assign start_o = start_q;
  assign nordy_o = nordy_q;
  assign ws_o    = ws_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/pcs_decode.sv
module pcs_decode #(
  parameter int ADDR_W    = 20,
  parameter int START_W   = 7,
  parameter int IO_ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               is_io,
  input  logic [START_W-1:0] start,
  input  logic               armed,
  output logic               hit
);
  localparam int CMP_LO = ADDR_W - START_W;

  logic [ADDR_W-1:0] io_addr;
  logic [ADDR_W-1:0] eff_addr;

  if (IO_ADDR_W < ADDR_W) begin : g_io_trunc
    assign io_addr = {{(ADDR_W-IO_ADDR_W){1'b0}}, addr[IO_ADDR_W-1:0]};
  end else begin : g_io_full
    assign io_addr = addr;
  end

  always_comb begin
    eff_addr = is_io ? io_addr : addr;
    hit      = armed && (eff_addr[ADDR_W-1:CMP_LO] >= start);
  end
endmodule

// File: rtl/pcs_waitctl.sv
module pcs_waitctl
  import pcs_pkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic            hit,
  input  logic [WS_W-1:0] ws,
  input  logic            nordy,
  input  logic            bus_rdy,
  output logic            cs_o,
  output logic            done_o,
  output logic            nordy_lat_o
);
  cyc_st_t         st_q, st_d;
  logic [WS_W-1:0] cnt_q, cnt_d;
  logic            nrd_q, nrd_d;
  logic            cnt_en, nrd_en;
  logic            cnt_zero, rdy_ok, done;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    rdy_ok   = nrd_q | bus_rdy;
    done     = (st_q == ST_ACTIVE) && cnt_zero && rdy_ok;
    st_d     = st_q;
    cnt_d    = cnt_q;
    nrd_d    = nrd_q;
    cnt_en   = 1'b0;
    nrd_en   = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cyc_start && hit) begin
          st_d   = ST_ACTIVE;
          cnt_d  = ws;
          nrd_d  = nordy;
          cnt_en = 1'b1;
          nrd_en = 1'b1;
        end
      end
      ST_ACTIVE: begin
        if (done) begin
          st_d = ST_IDLE;
        end else if (!cnt_zero) begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      nrd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (nrd_en) nrd_q <= nrd_d;
    end
  end

  assign cs_o        = (st_q == ST_ACTIVE);
  assign done_o      = done;
  assign nordy_lat_o = nrd_q;
endmodule

// File: rtl/periph_select_ctl.sv
module periph_select_ctl
  import pcs_pkg::*;
#(
  parameter int P_ADDR_W    = ADDR_W,
  parameter int P_DATA_W    = DATA_W,
  parameter int P_START_W   = START_W,
  parameter int P_WS_W      = WS_W,
  parameter int P_IO_ADDR_W = IO_ADDR_W,
  parameter int P_WS_RST    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [P_DATA_W-1:0] reg_wdata,
  output logic [P_DATA_W-1:0] reg_rdata,
  input  logic                cyc_start,
  input  logic [P_ADDR_W-1:0] cyc_addr,
  input  logic                cyc_io,
  input  logic                bus_rdy,
  output logic                cs_o,
  output logic                cyc_done
);
  logic [P_START_W-1:0] cfg_start;
  logic                 cfg_nordy;
  logic [P_WS_W-1:0]    cfg_ws;
  logic                 cfg_armed;
  logic                 dec_hit;
  logic                 cyc_nordy;

  pcs_regs #(
    .DATA_W (P_DATA_W),
    .START_W(P_START_W),
    .WS_W   (P_WS_W),
    .WS_RST (P_WS_RST)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .start_o(cfg_start),
    .nordy_o(cfg_nordy),
    .ws_o   (cfg_ws),
    .armed_o(cfg_armed)
  );

  pcs_decode #(
    .ADDR_W   (P_ADDR_W),
    .START_W  (P_START_W),
    .IO_ADDR_W(P_IO_ADDR_W)
  ) u_dec (
    .addr (cyc_addr),
    .is_io(cyc_io),
    .start(cfg_start),
    .armed(cfg_armed),
    .hit  (dec_hit)
  );

  pcs_waitctl #(
    .WS_W(P_WS_W)
  ) u_wait (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .hit        (dec_hit),
    .ws         (cfg_ws),
    .nordy      (cfg_nordy),
    .bus_rdy    (bus_rdy),
    .cs_o       (cs_o),
    .done_o     (cyc_done),
    .nordy_lat_o(cyc_nordy)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_rdata,
  input logic        cyc_start,
  input logic        bus_rdy,
  input logic        cs_o,
  input logic        cyc_done,
  input logic        nordy_lat
);
  logic touched_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) touched_q <= 1'b0;
    else if (reg_wr || reg_rd) touched_q <= 1'b1;
  end

  assert_disarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !touched_q |-> !cs_o);

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[8:3] == 6'd0);

  assert_cs_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_o) |-> $past(cyc_start));

  assert_cs_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cs_o);

  assert_rdy_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !bus_rdy) |-> nordy_lat);

  assert_done_in_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> cs_o);
endmodule

bind periph_select_ctl pcs_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .reg_rdata(reg_rdata),
  .cyc_start(cyc_start),
  .bus_rdy  (bus_rdy),
  .cs_o     (cs_o),
  .cyc_done (cyc_done),
  .nordy_lat(cyc_nordy)
);

// File: tb/tb_periph_select_ctl.sv
module tb_periph_select_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        cyc_start;
  logic [19:0] cyc_addr;
  logic        cyc_io;
  logic        bus_rdy;
  logic        cs_o, cyc_done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  periph_select_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_start(cyc_start),
    .cyc_addr(cyc_addr), .cyc_io(cyc_io), .bus_rdy(bus_rdy),
    .cs_o(cs_o), .cyc_done(cyc_done)
  );

  typedef struct packed {
    logic [15:0] cfg;
    logic [19:0] addr;
    logic        io;
    logic [3:0]  rdly;
    logic        sel;
    logic [3:0]  n;
  } vec_t;

  // cfg = start<<9 | ready_ignore<<2 | wait; n = selected clocks up to done
  localparam vec_t VECS [10] = '{
    '{16'h2006, 20'h20000, 1'b0, 4'd5, 1'b1, 4'd3},  // R4 boundary, R7
    '{16'h2006, 20'h1FFFF, 1'b0, 4'd0, 1'b0, 4'd0},  // R4 below, R9
    '{16'h2001, 20'hFE000, 1'b0, 4'd4, 1'b1, 4'd5},  // R8 ready late
    '{16'h2001, 20'h20000, 1'b0, 4'd0, 1'b1, 4'd2},  // R8 ready early
    '{16'h0004, 20'h00000, 1'b0, 4'd9, 1'b1, 4'd1},  // R7 zero waits
    '{16'h0407, 20'h04000, 1'b1, 4'd0, 1'b1, 4'd4},  // R5 I/O hit
    '{16'h0407, 20'h03FFF, 1'b1, 4'd0, 1'b0, 4'd0},  // R5 I/O below
    '{16'h2004, 20'hFE000, 1'b1, 4'd0, 1'b0, 4'd0},  // R5 high bits dropped
    '{16'h2004, 20'hFE000, 1'b0, 4'd0, 1'b1, 4'd1},  // R4 same addr memory
    '{16'h0003, 20'h12345, 1'b0, 4'd2, 1'b1, 4'd4}   // R8 full wait count
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] v);
    @(posedge clk); #1 reg_wr = 1'b1; reg_wdata = v;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic reg_read(output logic [15:0] v);
    @(posedge clk); #1 reg_rd = 1'b1; #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  // Issue one bus cycle and check select and done timing.
  task automatic run_cycle(input logic [19:0] a, input logic io, input int rdly,
                           input bit exp_sel, input int exp_n, input string tag);
    int n;
    bit saw_cs;
    n = 0;
    saw_cs = 0;
    @(posedge clk); #1 cyc_start = 1'b1; cyc_addr = a; cyc_io = io; bus_rdy = 1'b0;
    @(posedge clk); #1 cyc_start = 1'b0;
    if (!exp_sel) begin
      for (int i = 0; i < 4; i++) begin
        bus_rdy = 1'b1;
        #1 if (cs_o || cyc_done) saw_cs = 1;
        @(posedge clk); #1;
      end
      check(!saw_cs, {tag, " R9 no select"}, saw_cs, 0);
      bus_rdy = 1'b0;
    end else begin
      check(cs_o === 1'b1, {tag, " R6 cs rises"}, cs_o, 1);
      for (int i = 0; i < 16; i++) begin
        bus_rdy = (i >= rdly);
        #1;
        if (cyc_done === 1'b1) begin
          n = i + 1;
          break;
        end
        @(posedge clk); #1;
      end
      check(n == exp_n, {tag, " R7/R8 done clock"}, n, exp_n);
      @(posedge clk); #1 bus_rdy = 1'b0;
      check(cs_o === 1'b0, {tag, " R6 cs falls"}, cs_o, 0);
    end
  endtask

  initial begin
    logic [15:0] rv;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    cyc_start = 0; cyc_addr = '0; cyc_io = 0; bus_rdy = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    check(cs_o === 1'b0 && cyc_done === 1'b0, "R1 outputs low", {cs_o, cyc_done}, 0);
    check(reg_rdata === 16'h0003, "R1 reset word", reg_rdata, 16'h0003);
    // R2: reset start 0 would match anything, but block is not armed
    run_cycle(20'hFFFFF, 1'b0, 0, 1'b0, 0, "R2 disarmed");

    for (int k = 0; k < 10; k++) begin
      reg_write(VECS[k].cfg);
      run_cycle(VECS[k].addr, VECS[k].io, int'(VECS[k].rdly), VECS[k].sel,
                int'(VECS[k].n), $sformatf("vec%0d", k));
    end

    // R2: a read alone arms with reset fields (wait 3, ready needed)
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    run_cycle(20'h00000, 1'b0, 0, 1'b0, 0, "R2 after reset");
    reg_read(rv);
    check(rv === 16'h0003, "R2 read value", rv, 16'h0003);
    run_cycle(20'h00000, 1'b0, 0, 1'b1, 4, "R2 armed by read");

    // R3: reserved bits ignored
    reg_write(16'hFFFF);
    reg_read(rv);
    check(rv === 16'hFE07, "R3 reserved masked", rv, 16'hFE07);
    reg_write(16'h01F8);
    reg_read(rv);
    check(rv === 16'h0000, "R3 reserved only", rv, 16'h0000);

    // R8: ready held low long beyond the count
    reg_write(16'h0000);
    run_cycle(20'h00100, 1'b0, 7, 1'b1, 8, "R8 long stall");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule